// File: doc/BRIEF.md
# Clock-Mode Sequencer with PLL Lock Delay

This block decides how the core is clocked. During reset it reads a 3-bit code from three mode pins. From that code it loads a 16-bit clock-mode control word and picks the starting clock source. That source is either divide-by-two, divide-by-two with the internal oscillator enabled, stop, or PLL ×1 taken straight from the external source. After reset, software writes the control word to change the configuration.

Software can ask for PLL operation while the block is in divide mode. When it does, the block does not switch at once. It loads an 8-bit lock counter from the control word and keeps divide mode selected while that counter runs down. The counter steps once every sixteen input clocks. When it reaches zero, the block hands the clock over to the PLL. A software write that clears the PLL request sends the block back to divide mode on the next edge, and this also cancels any countdown in progress.

The analog PLL, the oscillator and the glitch-free clock multiplexer sit outside this block. This block only drives their select and enable lines.

Top module: `clkmode_seq`

## Requirements
- R1: While `rst` is high, the pins are sampled on every clock, with `mode_pins[2]` as the most significant bit of the code. On the next edge, `mode_reg` takes the value for that code: 000→0000h, 001→1000h, 010→2000h, 100→4000h, 110→6000h, 111→7000h, 011→0000h. For all of these codes, `pll_sel` and `lock_busy` are 0.
- R2: Reset code 101 loads `mode_reg` = 0007h and sets `pll_sel` = 1 on the same edge, with no countdown (`lock_busy` stays 0).
- R3: A write (`wr_en`=1 with `rst`=0) copies `wr_data[15:1]` into `mode_reg[15:1]` on the next edge. `mode_reg[0]` always equals `pll_sel`, and the written bit 0 has no effect.
- R4: The PLL request bit is bit 1 and the lock preset N is bits [10:3]. A write with bit 1 = 1 while in divide mode (`pll_sel`=0, `lock_busy`=0) sets `lock_busy` on the next edge.
- R5: After a lock start with preset N, `pll_sel` goes to 1 exactly 16·N+1 clocks after the write edge. Until then `pll_sel` stays 0 and `lock_busy` stays 1. In the same edge that `pll_sel` rises, `lock_busy` falls.
- R6: A preset of N = 0 selects the PLL on the clock right after the lock start.
- R7: A write with bit 1 = 0 clears `pll_sel` and `lock_busy` on the next edge from any state, and it cancels a running countdown.
- R8: A write with bit 1 = 1 made during a countdown or in PLL mode updates the register but neither restarts the countdown nor changes when `pll_sel` rises.
- R9: `osc_en` is 1 only after reset codes 100 and 111, and `stop_mode` is 1 only after reset code 011. Both keep their values until the next reset, whatever software writes.
- R10: Writes made while `rst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input reference clock |
| rst | input | 1 | Synchronous active-high reset; mode pins sampled while high |
| mode_pins | input | 3 | Clock-mode code pins, bit 2 most significant |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 16 | Control word to write |
| mode_reg | output | 16 | Control word; bit 0 is the read-only PLL-selected flag |
| pll_sel | output | 1 | Clock source select: 1 = PLL, 0 = divide mode |
| lock_busy | output | 1 | Lock countdown in progress |
| osc_en | output | 1 | Internal oscillator enable from the reset code |
| stop_mode | output | 1 | Stop mode chosen by the reset code |

## Verification
The effects of reset decoding, register writes, lock starts and cancellations all appear one clock after the edge that samples them. The PLL select is the one delayed result: it rises 16·N+1 clocks after the write edge that started the lock. In the bench, a behavioural model advances on each rising edge, using a plain integer wait counter set to 16·N. All five outputs are compared with the model on every falling edge, so each result is checked in exactly the cycle it is due, as well as in every cycle before and after. The stimulus covers presets of 0, small values and 255. It also covers repeated requests and cancellations made during a countdown, writes made while reset is held, and every pin code.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int WORD_W      = 16;
    localparam int LOCK_CNT_W  = 8;
    localparam int LOCK_PRE_W  = 4;
    localparam int F_NDIV      = 1;
    localparam int F_CNT_LO    = 3;
    localparam logic [2:0] CODE_PLL1 = 3'b101;

    typedef enum logic [1:0] {
        CM_DIV  = 2'd0,
        CM_LOCK = 2'd1,
        CM_PLL  = 2'd2
    } cm_state_e;

    typedef struct packed {
        logic [WORD_W-1:1] ctl;
        cm_state_e         state;
        logic              osc_en;
        logic              stop;
    } boot_cfg_t;

    function automatic boot_cfg_t decode_pins(input logic [2:0] code);
        boot_cfg_t        cfg;
        logic [WORD_W-1:0] word;
        cfg.state  = CM_DIV;
        cfg.osc_en = 1'b0;
        cfg.stop   = 1'b0;
        unique case (code)
            3'b000: word = 16'h0000;
            3'b001: word = 16'h1000;
            3'b010: word = 16'h2000;
            3'b011: begin word = 16'h0000; cfg.stop = 1'b1; end
            3'b100: begin word = 16'h4000; cfg.osc_en = 1'b1; end
            3'b101: begin word = 16'h0007; cfg.state = CM_PLL; end
            3'b110: word = 16'h6000;
            default: begin word = 16'h7000; cfg.osc_en = 1'b1; end
        endcase
        cfg.ctl = word[WORD_W-1:1];
        return cfg;
    endfunction

endpackage

// File: rtl/lock_prescaler.sv
module lock_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

    logic [PRE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && (phase_q == PRE_LAST);
endmodule

// File: rtl/lock_countdown.sv
module lock_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    input  logic             step,
    output logic             zero
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= preset;
        end else if (step && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign zero = (left_q == '0);
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
    import clkmode_pkg::*;
#(
    parameter int CNT_W = LOCK_CNT_W,
    parameter int PRE_W = LOCK_PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_pins,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] mode_reg,
    output logic              pll_sel,
    output logic              lock_busy,
    output logic              osc_en,
    output logic              stop_mode
);
    localparam int CNT_HI = F_CNT_LO + CNT_W - 1;

    boot_cfg_t         boot;
    logic [WORD_W-1:1] ctl_q;
    cm_state_e         st_q;
    logic              osc_q;
    logic              stop_q;
    logic              req_pll;
    logic              start_lock;
    logic              pre_tick;
    logic              tmr_zero;
    logic              wr_bit0_unused;

    assign boot           = decode_pins(mode_pins);
    assign req_pll        = wr_data[F_NDIV];
    assign start_lock     = wr_en && req_pll && (st_q == CM_DIV);
    assign wr_bit0_unused = wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= boot.ctl;
            st_q   <= boot.state;
            osc_q  <= boot.osc_en;
            stop_q <= boot.stop;
        end else begin
            if (wr_en) begin
                ctl_q <= wr_data[WORD_W-1:1];
            end
            if (wr_en && !req_pll) begin
                st_q <= CM_DIV;
            end else if (start_lock) begin
                st_q <= CM_LOCK;
            end else if ((st_q == CM_LOCK) && tmr_zero) begin
                st_q <= CM_PLL;
            end
        end
    end

    lock_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_lock),
        .run  (st_q == CM_LOCK),
        .tick (pre_tick)
    );

    lock_countdown #(.CNT_W(CNT_W)) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .load   (start_lock),
        .preset (wr_data[CNT_HI:F_CNT_LO]),
        .step   (pre_tick),
        .zero   (tmr_zero)
    );

    assign pll_sel   = (st_q == CM_PLL);
    assign lock_busy = (st_q == CM_LOCK);
    assign mode_reg  = {ctl_q, pll_sel};
    assign osc_en    = osc_q;
    assign stop_mode = stop_q;
endmodule

// File: rtl/clkmode_seq_chk.sv
module clkmode_seq_chk #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 4
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  mode_pins,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] mode_reg,
    input logic        pll_sel,
    input logic        lock_busy,
    input logic        osc_en,
    input logic        stop_mode
);
    localparam int unsigned LOCK_LIMIT = (2**PRE_W) * (2**CNT_W - 1) + 1;

    int unsigned lock_run;

    always_ff @(posedge clk) begin
        if (rst || !lock_busy) begin
            lock_run <= 0;
        end else begin
            lock_run <= lock_run + 1;
        end
    end

    p_reset_pll_r2: assert property (@(posedge clk)
        rst && (mode_pins == 3'b101) |=> pll_sel && !lock_busy);

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mode_reg[15:1] == $past(wr_data[15:1]));

    p_lock_start_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_data[1] && !pll_sel && !lock_busy |=> lock_busy);

    p_pll_after_lock_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_sel) && !$past(rst) |-> $past(lock_busy));

    p_lock_bound_r5: assert property (@(posedge clk) disable iff (rst)
        lock_run <= LOCK_LIMIT);

    p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_data[1] |=> !pll_sel && !lock_busy);

    p_lock_holds_r8: assert property (@(posedge clk) disable iff (rst)
        lock_busy && !(wr_en && !wr_data[1]) |=> lock_busy || pll_sel);

    p_boot_flags_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(osc_en) && $stable(stop_mode));

endmodule

bind clkmode_seq clkmode_seq_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .mode_pins (mode_pins),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .mode_reg  (mode_reg),
    .pll_sel   (pll_sel),
    .lock_busy (lock_busy),
    .osc_en    (osc_en),
    .stop_mode (stop_mode)
);

// File: tb/clkmode_seq_tb_top.sv
module clkmode_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  mode_pins;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] mode_reg;
    logic        pll_sel;
    logic        lock_busy;
    logic        osc_en;
    logic        stop_mode;

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag      = "R1";
    bit    done     = 1'b0;

    // behavioural reference: 0 = divide, 1 = locking, 2 = PLL
    int          m_mode = 0;
    int          m_wait = 0;
    logic [15:0] m_ctl  = 16'h0000;
    logic        m_osc  = 1'b0;
    logic        m_stop = 1'b0;
    bit          seen_edge = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkmode_seq dut_i (
        .clk       (clk),
        .rst       (rst),
        .mode_pins (mode_pins),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .mode_reg  (mode_reg),
        .pll_sel   (pll_sel),
        .lock_busy (lock_busy),
        .osc_en    (osc_en),
        .stop_mode (stop_mode)
    );

    always @(posedge clk) begin
        seen_edge = 1'b1;
        if (rst) begin
            m_osc  = 1'b0;
            m_stop = 1'b0;
            m_mode = 0;
            case (mode_pins)
                3'b000: m_ctl = 16'h0000;
                3'b001: m_ctl = 16'h1000;
                3'b010: m_ctl = 16'h2000;
                3'b011: begin m_ctl = 16'h0000; m_stop = 1'b1; end
                3'b100: begin m_ctl = 16'h4000; m_osc = 1'b1; end
                3'b101: begin m_ctl = 16'h0007; m_mode = 2; end
                3'b110: m_ctl = 16'h6000;
                default: begin m_ctl = 16'h7000; m_osc = 1'b1; end
            endcase
        end else begin
            if (wr_en) m_ctl = wr_data;
            if (wr_en && !wr_data[1]) begin
                m_mode = 0;
            end else if (m_mode == 0 && wr_en && wr_data[1]) begin
                m_mode = 1;
                m_wait = 16 * int'(wr_data[10:3]);
            end else if (m_mode == 1) begin
                if (m_wait == 0) m_mode = 2;
                else m_wait = m_wait - 1;
            end
        end
    end

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s at %0t: actual %h expected %h", tag, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (seen_edge && !done) begin
            check("mode_reg",  mode_reg,                {m_ctl[15:1], (m_mode == 2)});
            check("pll_sel",   {15'd0, pll_sel},        {15'd0, (m_mode == 2)});
            check("lock_busy", {15'd0, lock_busy},      {15'd0, (m_mode == 1)});
            check("osc_en",    {15'd0, osc_en},         {15'd0, m_osc});
            check("stop_mode", {15'd0, stop_mode},      {15'd0, m_stop});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [15:0] lock_word(input int n, input logic [15:0] extra);
        return extra | (16'(n) << 3) | 16'h0002;
    endfunction

    task automatic report();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst = 1'b1; mode_pins = 3'b000; wr_en = 1'b0; wr_data = 16'h0000;
        idle(2);
        // R1 / R2 / R9: every pin code while reset is held
        for (int code = 0; code < 8; code++) begin
            mode_pins = 3'(code);
            if (code == 5) tag = "R2";
            else if (code == 3 || code == 4 || code == 7) tag = "R9";
            else tag = "R1";
            idle(2);
        end
        // R10: writes during reset have no effect
        tag = "R10"; mode_pins = 3'b000;
        wr_en = 1'b1; wr_data = 16'hFFFF; idle(2); wr_en = 1'b0;
        // R2: leave reset straight into PLL x1
        tag = "R2"; mode_pins = 3'b101; idle(1);
        rst = 1'b0; idle(5);
        // R7: back to divide; written bit 0 ignored (R3)
        tag = "R7"; wr(16'h0001); idle(2);
        tag = "R3"; wr(16'hA5A4); idle(3);
        // R6: zero preset
        tag = "R6"; wr(lock_word(0, 16'h0000)); idle(4);
        tag = "R7"; wr(16'h0000); idle(2);
        // R5: small preset
        tag = "R5"; wr(lock_word(3, 16'h3000)); idle(60);
        // R7: cancel a running countdown
        tag = "R7"; wr(16'h0000); wr(lock_word(10, 16'h0000)); idle(40);
        wr(16'h0000); idle(200);
        // R8: repeated request during countdown and in PLL mode
        tag = "R8"; wr(lock_word(4, 16'h0000)); idle(20);
        wr(lock_word(1, 16'hF000)); idle(60);
        wr(lock_word(9, 16'h0800)); idle(4);
        // R4 / R5: full-scale preset
        tag = "R4"; wr(16'h0000); wr(lock_word(255, 16'h0000));
        tag = "R5"; idle(16 * 255 + 10);
        // R9: oscillator code, then writes leave the flags alone
        tag = "R9"; rst = 1'b1; mode_pins = 3'b100; idle(2);
        rst = 1'b0; mode_pins = 3'b000;
        wr(lock_word(0, 16'h7000)); idle(5); wr(16'h0000); idle(3);
        rst = 1'b1; mode_pins = 3'b011; idle(2);
        rst = 1'b0; wr(lock_word(2, 16'h0000)); idle(40);
        rst = 1'b1; mode_pins = 3'b111; idle(2);
        rst = 1'b0; wr(16'h0000); idle(4);
        report();
    end
endmodule